// File: doc/BRIEF.md
# Byte-Synchronous Transmit Framer with CRC

This block serialises byte-synchronous frames onto a single data line. When the first byte of a frame waits at the head of a show-ahead transmit FIFO, the block sends the configured sync character once or twice. It then sends every data character it pulls from the FIFO, least significant bit first. When the byte flagged as the last of its frame has gone out, the block can append a 16-bit check word. A parity bit, even or odd, may follow each data character. Sync characters and check-word characters never carry one.

The check word uses one of two generator polynomials. Its register starts from all zeros or all ones, and it is reloaded automatically at the start of every frame. Only data characters enter the calculation. A clear-to-send input, when enabled, holds off the start of every character, including sync and check-word characters. A character already on the line always completes. A bit timer divides the system clock and drives a line clock out next to the data. Every configuration input must stay steady while a frame is in progress.

Top module: `sync_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `txclk` is 0 and `fifo_rd` is 0. Whenever no character is being sent, `txd` stays 1 (mark).
- R2: A frame starts only when the FIFO is not empty. It opens with `cfg_sync_char` (SYNC_W bits, LSB first), sent once when `cfg_sync_two` is 0 and twice when it is 1, before any data character.
- R3: Each data character is taken with a one-cycle `fifo_rd` pulse while `fifo_data` shows the FIFO head. The character is sent as CHAR_W bits, LSB first. The byte with `fifo_last` = 1 is the final data character of its frame.
- R4: With `cfg_par_en` = 1, one parity bit follows the bits of each data character. With `cfg_par_odd` = 0 the parity bit makes the number of ones in character plus parity even, and with 1 it makes that number odd. Sync and check-word characters never carry parity.
- R5: With `cfg_crc_append` = 1, two 8-bit characters follow the final data character, without parity and with no gap: check bits [7:0] first, then [15:8], each LSB first. With 0, the line returns to mark after the final data character.
- R6: The check register c is updated once for each data bit in transmit order, with parity bits excluded. Each update computes f = bit XOR c[15], then c = (c << 1) XOR (f ? P : 0). P is 16'h8005 when `cfg_crc_ccitt` = 0 and 16'h1021 when it is 1. The result is not inverted.
- R7: At the start of every frame, c is loaded with 16'h0000 when `cfg_crc_preset_ones` = 0 and with 16'hFFFF when it is 1. Sync characters never enter c.
- R8: With `cfg_cts_en` = 1, a new character of any kind starts only while `cts` = 1. A character already started completes, and the line stays at mark while starts are held. With `cfg_cts_en` = 0, `cts` has no effect.
- R9: If the FIFO runs empty between data characters of a frame, the line stays at mark until the next byte arrives. The frame then continues, and its check word covers all of its bytes.
- R10: Each bit lasts BIT_DIV clock cycles. `txd` changes only on the edge where `txclk` goes to 0. `txclk` rises BIT_DIV/2 cycles later, so successive rising edges of `txclk` are BIT_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | CHAR_W | Byte at the FIFO head (show-ahead) |
| fifo_last | input | 1 | Head byte is the last one of its frame |
| fifo_rd | output | 1 | Pops the head byte this cycle |
| cts | input | 1 | Clear to send, active high |
| cfg_cts_en | input | 1 | Use `cts` to hold character starts |
| cfg_sync_char | input | SYNC_W | Sync character value |
| cfg_sync_two | input | 1 | Send two sync characters instead of one |
| cfg_par_en | input | 1 | Append a parity bit to data characters |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_crc_append | input | 1 | Append the check word at frame end |
| cfg_crc_ccitt | input | 1 | Select polynomial 16'h1021 instead of 16'h8005 |
| cfg_crc_preset_ones | input | 1 | Preset the check register to all ones |
| txd | output | 1 | Serial data line, mark = 1 |
| txclk | output | 1 | Line clock; data is stable around its rising edge |

## Verification
The bench targets gaps in the middle of a frame. It drops `cts` just after a byte is popped and lets the FIFO run dry after two bytes. A design that cut a character short or sent during the hold would show shifted or extra bits, and one that lost or restarted its check state across the gap would end with a wrong check word. Two frames are queued back to back with an all-ones preset, so a check register that is not reloaded, or one that absorbs sync characters, corrupts the second check word. Frames with parity and a check word show whether parity leaks onto sync or check characters. A frame without the append option shows whether a stray check word goes out.

// File: rtl/stf_pkg.sv
package stf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SYNC   = 3'd1,
    PH_DATA   = 3'd2,
    PH_CRC_LO = 3'd3,
    PH_CRC_HI = 3'd4
  } phase_e;

  localparam logic [15:0] POLY_A = 16'h8005;
  localparam logic [15:0] POLY_B = 16'h1021;

endpackage

// File: rtl/stf_bit_timer.sv
module stf_bit_timer #(
  parameter int BIT_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic line_clk
);

  localparam int CW   = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
  localparam int HALF = BIT_DIV / 2;
  localparam logic [CW-1:0] LAST_C = CW'(BIT_DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick  = (cnt_q == LAST_C);
  assign cnt_d = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      line_clk <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      line_clk <= (cnt_d >= HALF_C);
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);                                            // R10
  AST_CLK_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(line_clk) |-> $past(tick));                           // R10

endmodule

// File: rtl/stf_crc16.sv
module stf_crc16 import stf_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              preset_ones,
  input  logic              upd,
  input  logic              sel_b,
  input  logic [CHAR_W-1:0] din,
  output logic [15:0]       crc
);

  function automatic logic [15:0] crc_char(input logic [15:0] c_in,
                                           input logic [CHAR_W-1:0] d,
                                           input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < CHAR_W; i++) begin
      fb = d[i] ^ c[15];
      c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return c;
  endfunction

  logic [15:0] poly;
  assign poly = sel_b ? POLY_B : POLY_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc <= '0;
    end else if (init) begin
      crc <= preset_ones ? 16'hFFFF : 16'h0000;
    end else if (upd) begin
      crc <= crc_char(crc, din, poly);
    end
  end

  AST_INIT_NOT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    init |-> !upd);                                             // R7

endmodule

// File: rtl/stf_shifter.sv
module stf_shifter #(
  parameter int MAX_LEN = 9,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [MAX_LEN-1:0] ld_bits,
  input  logic [LEN_W-1:0]   ld_len,
  output logic               txd,
  output logic               empty
);

  logic [MAX_LEN-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;

  assign empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      txd   <= 1'b1;
    end else if (tick) begin
      if (!empty) begin
        txd   <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else if (load) begin
        txd   <= ld_bits[0];
        sh_q  <= ld_bits >> 1;
        cnt_q <= ld_len - 1'b1;
      end else begin
        txd   <= 1'b1;
      end
    end
  end

  AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    load |-> (tick && empty));                                  // R2

endmodule

// File: rtl/stf_sequencer.sv
module stf_sequencer import stf_pkg::*; #(
  parameter int CHAR_W  = 8,
  parameter int SYNC_W  = 8,
  parameter int MAX_LEN = 9,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               sh_empty,
  input  logic               fifo_empty,
  input  logic [CHAR_W-1:0]  fifo_data,
  input  logic               fifo_last,
  input  logic               cts,
  input  logic               cfg_cts_en,
  input  logic [SYNC_W-1:0]  cfg_sync_char,
  input  logic               cfg_sync_two,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               cfg_crc_append,
  input  logic [15:0]        crc,
  output logic               load,
  output logic [MAX_LEN-1:0] ld_bits,
  output logic [LEN_W-1:0]   ld_len,
  output logic               fifo_rd,
  output logic               crc_init,
  output logic               crc_upd
);

  localparam logic [LEN_W-1:0] LEN_SYNC = LEN_W'(SYNC_W);
  localparam logic [LEN_W-1:0] LEN_CHAR = LEN_W'(CHAR_W);
  localparam logic [LEN_W-1:0] LEN_PAR  = LEN_W'(CHAR_W + 1);
  localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(8);

  phase_e ph_q, ph_d;
  logic   go;
  logic   slot;
  logic   par_bit;

  assign go      = !cfg_cts_en || cts;
  assign slot    = tick && sh_empty && go;
  assign par_bit = (^fifo_data) ^ cfg_par_odd;

  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    ld_bits  = '0;
    ld_len   = '0;
    fifo_rd  = 1'b0;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    if (slot) begin
      case (ph_q)
        PH_IDLE: begin
          if (!fifo_empty) begin
            load     = 1'b1;
            ld_bits  = MAX_LEN'(cfg_sync_char);
            ld_len   = LEN_SYNC;
            crc_init = 1'b1;
            ph_d     = cfg_sync_two ? PH_SYNC : PH_DATA;
          end
        end
        PH_SYNC: begin
          load    = 1'b1;
          ld_bits = MAX_LEN'(cfg_sync_char);
          ld_len  = LEN_SYNC;
          ph_d    = PH_DATA;
        end
        PH_DATA: begin
          if (!fifo_empty) begin
            load    = 1'b1;
            fifo_rd = 1'b1;
            crc_upd = 1'b1;
            if (cfg_par_en) begin
              ld_bits = MAX_LEN'({par_bit, fifo_data});
              ld_len  = LEN_PAR;
            end else begin
              ld_bits = MAX_LEN'(fifo_data);
              ld_len  = LEN_CHAR;
            end
            if (fifo_last) begin
              ph_d = cfg_crc_append ? PH_CRC_LO : PH_IDLE;
            end
          end
        end
        PH_CRC_LO: begin
          load    = 1'b1;
          ld_bits = MAX_LEN'(crc[7:0]);
          ld_len  = LEN_BYTE;
          ph_d    = PH_CRC_HI;
        end
        PH_CRC_HI: begin
          load    = 1'b1;
          ld_bits = MAX_LEN'(crc[15:8]);
          ld_len  = LEN_BYTE;
          ph_d    = PH_IDLE;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= ph_d;
  end

  AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (rst)
    load |-> (!cfg_cts_en || cts));                             // R8
  AST_NO_POP_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_DATA) |-> !fifo_rd);                            // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);                                   // R3

endmodule

// File: rtl/sync_tx_framer.sv
module sync_tx_framer import stf_pkg::*; #(
  parameter int CHAR_W  = 8,
  parameter int SYNC_W  = 8,
  parameter int BIT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_rd,
  input  logic              cts,
  input  logic              cfg_cts_en,
  input  logic [SYNC_W-1:0] cfg_sync_char,
  input  logic              cfg_sync_two,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_crc_append,
  input  logic              cfg_crc_ccitt,
  input  logic              cfg_crc_preset_ones,
  output logic              txd,
  output logic              txclk
);

  localparam int LEN_A   = (CHAR_W + 1 > SYNC_W) ? CHAR_W + 1 : SYNC_W;
  localparam int MAX_LEN = (LEN_A > 8) ? LEN_A : 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic               tick;
  logic               sh_empty;
  logic               load;
  logic [MAX_LEN-1:0] ld_bits;
  logic [LEN_W-1:0]   ld_len;
  logic               crc_init;
  logic               crc_upd;
  logic [15:0]        crc;

  stf_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .line_clk (txclk)
  );

  stf_sequencer #(
    .CHAR_W (CHAR_W),
    .SYNC_W (SYNC_W),
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .sh_empty      (sh_empty),
    .fifo_empty    (fifo_empty),
    .fifo_data     (fifo_data),
    .fifo_last     (fifo_last),
    .cts           (cts),
    .cfg_cts_en    (cfg_cts_en),
    .cfg_sync_char (cfg_sync_char),
    .cfg_sync_two  (cfg_sync_two),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_odd   (cfg_par_odd),
    .cfg_crc_append(cfg_crc_append),
    .crc           (crc),
    .load          (load),
    .ld_bits       (ld_bits),
    .ld_len        (ld_len),
    .fifo_rd       (fifo_rd),
    .crc_init      (crc_init),
    .crc_upd       (crc_upd)
  );

  stf_crc16 #(.CHAR_W(CHAR_W)) u_crc (
    .clk        (clk),
    .rst        (rst),
    .init       (crc_init),
    .preset_ones(cfg_crc_preset_ones),
    .upd        (crc_upd),
    .sel_b      (cfg_crc_ccitt),
    .din        (fifo_data),
    .crc        (crc)
  );

  stf_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .load   (load),
    .ld_bits(ld_bits),
    .ld_len (ld_len),
    .txd    (txd),
    .empty  (sh_empty)
  );

  AST_TXD_MOVES_WITH_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> !txclk);                                  // R10
  AST_MARK_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    (tick && sh_empty && !load) |=> txd);                       // R1

endmodule

// File: tb/test_sync_tx_framer.sv
module test_sync_tx_framer;

  localparam int BD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_empty, fifo_last, fifo_rd;
  logic [7:0] fifo_data;
  logic       cts = 1'b1, cfg_cts_en = 1'b0;
  logic [7:0] cfg_sync_char = 8'h16;
  logic       cfg_sync_two = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_crc_append = 1'b0, cfg_crc_ccitt = 1'b0, cfg_crc_preset_ones = 1'b0;
  logic       txd, txclk;

  always #10 clk = ~clk;

  sync_tx_framer #(.CHAR_W(8), .SYNC_W(8), .BIT_DIV(BD)) i_sync_tx_framer (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_rd(fifo_rd), .cts(cts), .cfg_cts_en(cfg_cts_en),
    .cfg_sync_char(cfg_sync_char), .cfg_sync_two(cfg_sync_two),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_crc_append(cfg_crc_append), .cfg_crc_ccitt(cfg_crc_ccitt),
    .cfg_crc_preset_ones(cfg_crc_preset_ones), .txd(txd), .txclk(txclk)
  );

  // show-ahead FIFO model
  logic [8:0] fmem [0:255];
  logic [7:0] wp = 8'd0;
  logic [7:0] rp = 8'd0;
  int         npops = 0;
  assign fifo_empty = (wp == rp);
  assign fifo_data  = fmem[rp][7:0];
  assign fifo_last  = fmem[rp][8];

  always @(posedge clk) begin
    if (fifo_rd) begin
      rp    <= rp + 8'd1;
      npops <= npops + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected characters
  int    eq_val[$];
  int    eq_len[$];
  string eq_tag[$];

  task automatic exp_char(input int v, input int n, input string tag);
    eq_val.push_back(v);
    eq_len.push_back(n);
    eq_tag.push_back(tag);
  endtask

  function automatic logic [15:0] model_crc(input logic [15:0] c_in,
                                            input logic [7:0] d, input bit sel_b);
    logic [15:0] c;
    logic [15:0] p;
    c = c_in;
    p = sel_b ? 16'h1021 : 16'h8005;
    for (int i = 0; i < 8; i++) begin
      if (d[i] ^ c[15]) c = {c[14:0], 1'b0} ^ p;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  logic [7:0] fb [0:15];

  task automatic frame_expect(input int n, input string crc_tag);
    logic [15:0] c;
    logic        p;
    c = cfg_crc_preset_ones ? 16'hFFFF : 16'h0000;
    exp_char(int'(cfg_sync_char), 8, "R2 sync");
    if (cfg_sync_two) exp_char(int'(cfg_sync_char), 8, "R2 second sync");
    for (int i = 0; i < n; i++) begin
      c = model_crc(c, fb[i], cfg_crc_ccitt);
      if (cfg_par_en) begin
        p = cfg_par_odd ? ~(^fb[i]) : (^fb[i]);
        exp_char(int'({p, fb[i]}), 9, "R4 data+parity");
      end else begin
        exp_char(int'(fb[i]), 8, "R3 data");
      end
    end
    if (cfg_crc_append) begin
      exp_char(int'(c[7:0]), 8, {crc_tag, " crc low"});
      exp_char(int'(c[15:8]), 8, {crc_tag, " crc high"});
    end
  endtask

  task automatic frame_push(input int from, input int to, input int n);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      fmem[wp] = {(i == n - 1), fb[i]};
      wp = wp + 8'd1;
    end
  endtask

  // monitor: samples txd at each rising txclk, away from the clock edge
  bit  in_char = 0;
  int  cur_v, cur_n, idx;
  bit  prev_clk = 0;
  int  cyc = 0, last_rise = -1;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      in_char   = 0;
      prev_clk  = 0;
      last_rise = -1;
    end else begin
      if (txclk && !prev_clk) begin
        if (last_rise >= 0) chk((cyc - last_rise) == BD, "R10 bit period", cyc - last_rise, BD);
        last_rise = cyc;
        if (!in_char) begin
          if (eq_val.size() == 0) begin
            if (txd !== 1'b1) chk(0, "R1 space bit while idle", int'(txd), 1);
          end else if (txd == 1'b0 || (eq_val[0] & 1) == 1) begin
            in_char = 1;
            cur_v   = 0;
            cur_n   = eq_len[0];
            idx     = 0;
          end
        end
        if (in_char) begin
          if (txd) cur_v = cur_v | (1 << idx);
          idx++;
          if (idx == cur_n) begin
            chk(cur_v == eq_val[0], eq_tag[0], cur_v, eq_val[0]);
            void'(eq_val.pop_front());
            void'(eq_len.pop_front());
            void'(eq_tag.pop_front());
            in_char = 0;
          end
        end
      end
      prev_clk = txclk;
    end
  end

  task automatic wait_drain;
    while (eq_val.size() != 0 || in_char || !fifo_empty) @(negedge clk);
    repeat (12 * BD) @(negedge clk);
  endtask

  task automatic wait_pops(input int target);
    while (npops < target) @(negedge clk);
  endtask

  task automatic hold_window(input int target_pops, input string req);
    bit bad;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (txd !== 1'b1 || npops != target_pops) bad = 1;
    end
    chk(!bad, req, npops, target_pops);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int p0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(txclk == 1'b0, "R1 txclk after reset", int'(txclk), 0);
    chk(fifo_rd == 1'b0, "R1 fifo_rd after reset", int'(fifo_rd), 0);
    repeat (40) @(negedge clk);
    chk(txd == 1'b1 && npops == 0, "R1 mark with empty FIFO", int'(txd), 1);

    // Frame A: one sync, no parity, polynomial 8005, preset zero (R2 R3 R5 R6)
    cfg_crc_append = 1; cfg_crc_ccitt = 0; cfg_crc_preset_ones = 0;
    fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'hA5;
    frame_expect(3, "R6");
    p0 = npops;
    frame_push(0, 3, 3);
    wait_drain();
    chk(npops - p0 == 3, "R3 one pop per byte", npops - p0, 3);

    // Frame B: two syncs, even parity, polynomial 1021, preset ones (R4 R6 R7)
    cfg_sync_char = 8'h32; cfg_sync_two = 1; cfg_par_en = 1; cfg_par_odd = 0;
    cfg_crc_ccitt = 1; cfg_crc_preset_ones = 1;
    fb[0] = 8'h00; fb[1] = 8'h7F; fb[2] = 8'hC3; fb[3] = 8'h01;
    frame_expect(4, "R7");
    frame_push(0, 4, 4);
    wait_drain();

    // Frame C: odd parity, no check word appended (R4 R5)
    cfg_sync_char = 8'h16; cfg_sync_two = 0; cfg_par_odd = 1; cfg_crc_append = 0;
    fb[0] = 8'hE8; fb[1] = 8'h55;
    frame_expect(2, "R5");
    frame_push(0, 2, 2);
    wait_drain();
    chk(eq_val.size() == 0 && txd == 1'b1, "R5 no check word without append", int'(txd), 1);

    // Frames D and E back to back: preset reloaded per frame (R7)
    cfg_par_en = 0; cfg_crc_append = 1; cfg_crc_ccitt = 0; cfg_crc_preset_ones = 1;
    fb[0] = 8'h9C; fb[1] = 8'h21;
    frame_expect(2, "R7");
    frame_push(0, 2, 2);
    fb[0] = 8'h4E; fb[1] = 8'hF0; fb[2] = 8'h13;
    frame_expect(3, "R7");
    frame_push(0, 3, 3);
    wait_drain();

    // CTS hold before start and in mid-frame (R8)
    cfg_cts_en = 1; cts = 0; cfg_crc_preset_ones = 0;
    fb[0] = 8'h10; fb[1] = 8'h22; fb[2] = 8'h44; fb[3] = 8'h66;
    frame_expect(4, "R8");
    p0 = npops;
    frame_push(0, 4, 4);
    hold_window(p0, "R8 no start while cts low");
    cts = 1;
    wait_pops(p0 + 2);
    cts = 0;
    repeat (40) @(negedge clk);
    hold_window(p0 + 2, "R8 held at character boundary");
    cts = 1;
    wait_drain();
    chk(npops - p0 == 4, "R8 all bytes after release", npops - p0, 4);

    // CTS ignored when not enabled (R8)
    cfg_cts_en = 0; cts = 0;
    fb[0] = 8'hB6; fb[1] = 8'h0D;
    frame_expect(2, "R8");
    p0 = npops;
    frame_push(0, 2, 2);
    wait_drain();
    chk(npops - p0 == 2, "R8 cts ignored when disabled", npops - p0, 2);
    cts = 1;

    // FIFO underrun in mid-frame (R9)
    cfg_crc_ccitt = 1; cfg_crc_preset_ones = 1;
    fb[0] = 8'h08; fb[1] = 8'h3C; fb[2] = 8'h5A; fb[3] = 8'h81;
    frame_expect(4, "R9");
    p0 = npops;
    frame_push(0, 2, 4);
    wait_pops(p0 + 2);
    repeat (40) @(negedge clk);
    hold_window(p0 + 2, "R9 mark during underrun");
    frame_push(2, 4, 4);
    wait_drain();
    chk(npops - p0 == 4, "R9 frame resumes", npops - p0, 4);

    chk(eq_val.size() == 0, "R2 all characters seen", eq_val.size(), 0);
    finish_run();
  end

endmodule